// File: doc/BRIEF.md
# Dual Store Queue Burst Writer

This block gathers CPU stores into two 32-byte write-combining queues and then pushes a whole queue out to external memory as a single aligned burst. Stores go to a fixed 64 MB address window. Within that window, one address bit picks the queue and three bits pick the 32-bit slot inside it. The remaining middle bits do not affect where the data is stored.

A flush command sent to the same window copies the chosen queue to memory. The transfer is eight 32-bit beats on a valid/ready master port. The destination address is built in one of two ways. In translated mode, the upper bits come from a page number supplied from outside. In untranslated mode, they come from a small base register kept for each queue, together with the request address.

Because there are two queues, software can fill one while the other drains. Only the queue that is draining is blocked, and only until its burst is complete.

Top module: `sq_burst_writer`

## Requirements
- R1: A store is taken only when address bits 31:26 are 111000 and bits 1:0 are 00. Any other store changes no queue and raises no stall.
- R2: For an accepted store, address bit 5 picks the queue (0 = queue 0, 1 = queue 1) and bits 4:2 pick the slot. A longword store writes data bits 31:0 into that slot.
- R3: A quadword store writes data bits 31:0 to slot {a[4:3],0} and data bits 63:32 to slot {a[4:3],1}. Address bit 2 is ignored for a quadword store.
- R4: When the block is idle, an in-window flush is accepted at the clock edge, and bw_valid is high from the next cycle. The burst has eight beats carrying slots 0 to 7 in ascending order, with bw_last high only on the eighth beat. bw_valid is low in the cycle after the final handshake, and is low out of reset.
- R5: While bw_valid is high and bw_ready is low, bw_data, bw_addr and bw_last hold their values.
- R6: bw_addr bits 4:0 are always zero. In translated mode (xlat_en high at flush), bw_addr[28:10] = xlat_page and bw_addr[9:5] = flush address bits 9:5.
- R7: In untranslated mode, bw_addr[28:26] is the base register of the flushed queue and bw_addr[25:5] is flush address bits 25:5. A base register is loaded from base_data when base_we is high, with base_sel choosing the queue. Both base registers reset to 0.
- R8: During a burst, a store to the other queue raises no stall and is written at that clock edge.
- R9: During a burst, a store to the draining queue raises st_stall in the same cycle, and nothing is written while the stall lasts. The stall drops in the cycle after the final handshake, and the held store is then written.
- R10: An in-window flush that arrives during a burst raises fl_stall and does not start a burst. A transfer does not clear the queue, so flushing it again sends the same data.
- R11: A flush whose address bits 31:26 are not 111000 is ignored: no burst starts and no stall is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request |
| st_addr | input | 32 | Store address |
| st_quad | input | 1 | 1 = 64-bit store, 0 = 32-bit store |
| st_data | input | 64 | Store data (low word used for a longword store) |
| st_stall | output | 1 | Store held; keep the request asserted |
| fl_valid | input | 1 | Flush request |
| fl_addr | input | 32 | Flush address |
| fl_stall | output | 1 | Flush held; keep the request asserted |
| xlat_en | input | 1 | Selects translated destination mode for the flush |
| xlat_page | input | 19 | Translated page bits 28:10 |
| base_we | input | 1 | Base register write enable |
| base_sel | input | 1 | Base register select |
| base_data | input | 3 | Base register value (destination bits 28:26) |
| bw_valid | output | 1 | Burst beat valid |
| bw_ready | input | 1 | Burst beat accepted |
| bw_addr | output | 29 | 32-byte-aligned burst start address |
| bw_data | output | 32 | Beat data |
| bw_last | output | 1 | Final beat of the burst |

## Verification
A store that is not stalled is written at the clock edge where it is sampled, and the next burst from that queue carries it. A flush taken at edge N shows up as bw_valid one cycle later, after one register stage. st_stall and fl_stall are combinational and follow the request within the same cycle. Both stalls clear in the cycle after the eighth handshake. The bench drives inputs on the falling edge and samples one nanosecond later, so each check reads a settled value. For every beat, the bench checks the data against its own model of the queue slots, and it compares each stall flag with the value expected in that exact cycle.

// File: rtl/sqbw_pkg.sv
package sqbw_pkg;
  localparam logic [5:0] WIN_TAG = 6'b111000;

  function automatic logic in_window(input logic [31:0] a);
    return a[31:26] == WIN_TAG;
  endfunction
endpackage

// File: rtl/sqbw_queue.sv
module sqbw_queue #(
  parameter int unsigned SLOTS = 8,
  parameter int unsigned LW_W  = 32,
  localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                wr_quad,
  input  logic [SLOT_W-1:0]   wr_slot,
  input  logic [2*LW_W-1:0]   wr_data,
  input  logic                locked,
  input  logic [SLOT_W-1:0]   rd_slot,
  output logic [LW_W-1:0]     rd_data
);
  logic [LW_W-1:0] slot_q [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam logic [SLOT_W-1:0] IDX = SLOT_W'(s);
    logic            sel, hi;
    logic [LW_W-1:0] mem_q;

    always_comb begin
      if (wr_quad) begin
        sel = wr_slot[SLOT_W-1:1] == IDX[SLOT_W-1:1];
        hi  = IDX[0];
      end else begin
        sel = wr_slot == IDX;
        hi  = 1'b0;
      end
    end

    // datapath storage: no reset, explicit clock enable
    always_ff @(posedge clk) begin
      if (wr_en && sel) mem_q <= hi ? wr_data[2*LW_W-1:LW_W] : wr_data[LW_W-1:0];
    end

    assign slot_q[s] = mem_q;
  end

  assign rd_data = slot_q[rd_slot];

  // R9: the queue under transfer never sees a write
  p_no_write_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && locked));
endmodule

// File: rtl/sqbw_drain.sv
module sqbw_drain #(
  parameter int unsigned SLOTS = 8,
  parameter int unsigned LW_W  = 32,
  parameter int unsigned PA_W  = 29,
  localparam int unsigned SLOT_W = $clog2(SLOTS),
  localparam int unsigned OFF_W  = SLOT_W + $clog2(LW_W/8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_q,
  input  logic [PA_W-1:0]   start_addr,
  output logic              busy,
  output logic              act_q,
  output logic [SLOT_W-1:0] rd_slot,
  input  logic [LW_W-1:0]   rd_data,
  output logic              bw_valid,
  input  logic              bw_ready,
  output logic [PA_W-1:0]   bw_addr,
  output logic [LW_W-1:0]   bw_data,
  output logic              bw_last
);
  localparam logic [SLOT_W-1:0] LAST_BEAT = SLOT_W'(SLOTS-1);

  logic              busy_q, busy_d;
  logic              q_q, q_d;
  logic [SLOT_W-1:0] beat_q, beat_d;
  logic [PA_W-1:0]   addr_q, addr_d;

  always_comb begin
    busy_d = busy_q;
    q_d    = q_q;
    beat_d = beat_q;
    addr_d = addr_q;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        q_d    = start_q;
        beat_d = '0;
        addr_d = start_addr;
      end
    end else if (bw_ready) begin
      if (beat_q == LAST_BEAT) busy_d = 1'b0;
      else                     beat_d = beat_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      q_q    <= 1'b0;
      beat_q <= '0;
      addr_q <= '0;
    end else begin
      busy_q <= busy_d;
      q_q    <= q_d;
      beat_q <= beat_d;
      addr_q <= addr_d;
    end
  end

  assign busy     = busy_q;
  assign act_q    = q_q;
  assign rd_slot  = beat_q;
  assign bw_valid = busy_q;
  assign bw_addr  = addr_q;
  assign bw_data  = rd_data;
  assign bw_last  = busy_q && (beat_q == LAST_BEAT);

  // R5: a waiting beat does not change
  p_beat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bw_valid && !bw_ready |=> bw_valid && $stable(bw_data) && $stable(bw_addr) && $stable(bw_last));
  // R4: the burst ends after the last handshake
  p_burst_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bw_valid && bw_ready && bw_last |=> !bw_valid);
  // R6: start address is block aligned
  p_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bw_valid |-> bw_addr[OFF_W-1:0] == '0);
endmodule

// File: rtl/sq_burst_writer.sv
module sq_burst_writer #(
  parameter int unsigned SLOTS = 8,
  parameter int unsigned LW_W  = 32,
  parameter int unsigned PA_W  = 29,
  localparam int unsigned SLOT_W   = $clog2(SLOTS),
  localparam int unsigned OFF_W    = SLOT_W + $clog2(LW_W/8),
  localparam int unsigned PAGE_LSB = 10,
  localparam int unsigned BASE_LSB = 26,
  localparam int unsigned PAGE_W   = PA_W - PAGE_LSB,
  localparam int unsigned BASE_W   = PA_W - BASE_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  input  logic [31:0]       st_addr,
  input  logic              st_quad,
  input  logic [2*LW_W-1:0] st_data,
  output logic              st_stall,
  input  logic              fl_valid,
  input  logic [31:0]       fl_addr,
  output logic              fl_stall,
  input  logic              xlat_en,
  input  logic [PAGE_W-1:0] xlat_page,
  input  logic              base_we,
  input  logic              base_sel,
  input  logic [BASE_W-1:0] base_data,
  output logic              bw_valid,
  input  logic              bw_ready,
  output logic [PA_W-1:0]   bw_addr,
  output logic [LW_W-1:0]   bw_data,
  output logic              bw_last
);
  import sqbw_pkg::*;

  logic              busy, act_q;
  logic [SLOT_W-1:0] rd_slot;
  logic [LW_W-1:0]   q_rd [2];
  logic              st_hit, st_q, st_go, fl_hit, fl_q, fl_go;
  logic [PA_W-1:0]   dest;
  logic [BASE_W-1:0] base_q [2];
  logic [BASE_W-1:0] base_d [2];

  // request decode
  always_comb begin
    st_hit   = st_valid && in_window(st_addr) && (st_addr[1:0] == 2'b00);
    st_q     = st_addr[OFF_W];
    st_stall = st_hit && busy && (act_q == st_q);
    st_go    = st_hit && !st_stall;
    fl_hit   = fl_valid && in_window(fl_addr);
    fl_q     = fl_addr[OFF_W];
    fl_stall = fl_hit && busy;
    fl_go    = fl_hit && !busy;
  end

  // destination address
  always_comb begin
    if (xlat_en) dest = {xlat_page, fl_addr[PAGE_LSB-1:OFF_W], {OFF_W{1'b0}}};
    else         dest = {base_q[fl_q], fl_addr[BASE_LSB-1:OFF_W], {OFF_W{1'b0}}};
  end

  // per-queue base registers
  for (genvar q = 0; q < 2; q++) begin : g_base
    always_comb begin
      base_d[q] = base_q[q];
      if (base_we && (base_sel == 1'(q))) base_d[q] = base_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) base_q[q] <= '0;
      else        base_q[q] <= base_d[q];
    end
  end

  for (genvar q = 0; q < 2; q++) begin : g_queue
    sqbw_queue #(.SLOTS(SLOTS), .LW_W(LW_W)) i_queue (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (st_go && (st_q == 1'(q))),
      .wr_quad (st_quad),
      .wr_slot (st_addr[OFF_W-1:2]),
      .wr_data (st_data),
      .locked  (busy && (act_q == 1'(q))),
      .rd_slot (rd_slot),
      .rd_data (q_rd[q])
    );
  end

  sqbw_drain #(.SLOTS(SLOTS), .LW_W(LW_W), .PA_W(PA_W)) i_drain (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (fl_go),
    .start_q    (fl_q),
    .start_addr (dest),
    .busy       (busy),
    .act_q      (act_q),
    .rd_slot    (rd_slot),
    .rd_data    (q_rd[act_q]),
    .bw_valid   (bw_valid),
    .bw_ready   (bw_ready),
    .bw_addr    (bw_addr),
    .bw_data    (bw_data),
    .bw_last    (bw_last)
  );

  // R9: a stall only occurs while a burst is on the port
  p_stall_in_burst_r9: assert property (@(posedge clk) disable iff (!rst_n)
    st_stall |-> bw_valid);
  // R10: a held flush starts nothing new
  p_flush_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fl_stall && !(bw_ready && bw_last) |=> bw_valid);
  // R11: a flush outside the window never launches a burst
  p_outside_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bw_valid && !(fl_valid && fl_addr[31:26] == 6'b111000) |=> !bw_valid);
endmodule

// File: tb/test_sq_burst_writer.sv
`timescale 1ns/1ps
module test_sq_burst_writer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        st_valid, st_quad, fl_valid, xlat_en, base_we, base_sel, bw_ready;
  logic [31:0] st_addr, fl_addr;
  logic [63:0] st_data;
  logic [18:0] xlat_page;
  logic [2:0]  base_data;
  logic        st_stall, fl_stall, bw_valid, bw_last;
  logic [28:0] bw_addr;
  logic [31:0] bw_data;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [2][8];
  logic [2:0]  base_m [2];

  always #2 clk = ~clk;

  sq_burst_writer i_sq_burst_writer (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr), .st_quad(st_quad),
    .st_data(st_data), .st_stall(st_stall), .fl_valid(fl_valid), .fl_addr(fl_addr),
    .fl_stall(fl_stall), .xlat_en(xlat_en), .xlat_page(xlat_page), .base_we(base_we),
    .base_sel(base_sel), .base_data(base_data), .bw_valid(bw_valid), .bw_ready(bw_ready),
    .bw_addr(bw_addr), .bw_data(bw_data), .bw_last(bw_last));

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [28:0] exp_dest(input logic [31:0] a, input bit xl, input logic [18:0] pg);
    if (xl) return {pg, a[9:5], 5'b0};
    return {base_m[a[5]], a[25:5], 5'b0};
  endfunction

  task automatic store(input logic [31:0] a, input logic [63:0] d, input bit quad);
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_data = d; st_quad = quad;
    #1 chk("R1", "no stall while idle", st_stall, 0);
    @(negedge clk);
    st_valid = 1'b0;
    if (a[31:26] == 6'b111000 && a[1:0] == 2'b00) begin
      if (quad) begin
        model[a[5]][{a[4:3], 1'b0}] = d[31:0];
        model[a[5]][{a[4:3], 1'b1}] = d[63:32];
      end else model[a[5]][a[4:2]] = d[31:0];
    end
  endtask

  task automatic set_base(input bit q, input logic [2:0] v);
    @(negedge clk);
    base_we = 1'b1; base_sel = q; base_data = v;
    @(negedge clk);
    base_we = 1'b0;
    base_m[q] = v;
  endtask

  task automatic flush(input logic [31:0] a, input bit xl, input logic [18:0] pg, input bit expect_go);
    @(negedge clk);
    fl_valid = 1'b1; fl_addr = a; xlat_en = xl; xlat_page = pg;
    @(negedge clk);
    fl_valid = 1'b0;
    #1 chk(expect_go ? "R4" : "R11", "bw_valid one cycle after flush", bw_valid, expect_go);
  endtask

  task automatic drain_check(input bit q, input logic [28:0] ea, input int stall_every, input string req);
    int beat = 0;
    int guard = 0;
    while (beat < 8 && guard < 200) begin
      @(negedge clk);
      guard++;
      bw_ready = (stall_every == 0) ? 1'b1 : ((guard % stall_every) != 0);
      #1;
      chk(req, "beat valid", bw_valid, 1);
      chk(req, $sformatf("q%0d beat %0d data", q, beat), bw_data, model[q][beat]);
      chk("R6", "burst address", bw_addr, ea);
      chk("R4", "last flag", bw_last, beat == 7);
      if (bw_valid && bw_ready) beat++;
    end
    @(negedge clk);
    bw_ready = 1'b0;
    #1 chk("R4", "valid low after last beat", bw_valid, 0);
  endtask

  task automatic t_reset;
    #1;
    chk("R4", "reset bw_valid", bw_valid, 0);
    chk("R9", "reset st_stall", st_stall, 0);
    chk("R10", "reset fl_stall", fl_stall, 0);
  endtask

  task automatic t_longword;
    logic [31:0] a;
    set_base(0, 3'd5);
    set_base(1, 3'd2);
    for (int i = 0; i < 8; i++) store(32'hE000_0000 | (i << 2), 64'(32'hA000_0000 + i), 0);
    for (int i = 0; i < 8; i++) store(32'hE3FF_FFE0 | (i << 2), 64'(32'hB100_0000 + 7 * i), 0);
    a = 32'hE0AB_CDC0;
    flush(a, 0, '0, 1);
    drain_check(0, exp_dest(a, 0, '0), 0, "R2");
    chk("R7", "untranslated base q0", exp_dest(a, 0, '0), {3'd5, a[25:5], 5'b0});
    a = 32'hE3FF_FFE0;
    flush(a, 0, '0, 1);
    drain_check(1, exp_dest(a, 0, '0), 0, "R7");
  endtask

  task automatic t_quad;
    store(32'hE000_0008, 64'h1111_2222_3333_4444, 1);
    store(32'hE000_001C, 64'h5555_6666_7777_8888, 1);
    chk("R3", "quad low word slot 2", model[0][2], 32'h3333_4444);
    flush(32'hE000_0000, 0, '0, 1);
    drain_check(0, exp_dest(32'hE000_0000, 0, '0), 3, "R3");
  endtask

  task automatic t_xlat;
    logic [31:0] a;
    a = 32'hE000_03A0;
    flush(a, 1, 19'h5A5A5, 1);
    drain_check(1, {19'h5A5A5, 5'b11101, 5'b0}, 2, "R6");
  endtask

  task automatic t_ignore;
    store(32'hE400_0000, 64'hDEAD_0001, 0);
    store(32'hE000_0006, 64'hDEAD_0002, 0);
    store(32'hDFFF_FFFC, 64'hDEAD_0003, 0);
    @(negedge clk);
    fl_valid = 1'b1; fl_addr = 32'h1000_0000;
    #1 chk("R11", "no flush stall outside window", fl_stall, 0);
    @(negedge clk);
    fl_valid = 1'b0;
    #1 chk("R11", "outside flush ignored", bw_valid, 0);
    flush(32'hE000_0000, 0, '0, 1);
    drain_check(0, exp_dest(32'hE000_0000, 0, '0), 0, "R1");
  endtask

  task automatic t_pingpong;
    flush(32'hE000_0000, 0, '0, 1);
    @(negedge clk);
    st_valid = 1'b1; st_addr = 32'hE000_0024; st_data = 64'h0000_0000_CAFE_0001; st_quad = 1'b0;
    #1 chk("R8", "other queue not stalled", st_stall, 0);
    @(negedge clk);
    st_valid = 1'b0;
    model[1][1] = 32'hCAFE_0001;
    fl_valid = 1'b1; fl_addr = 32'hE000_0020;
    #1 chk("R10", "flush during burst stalled", fl_stall, 1);
    @(negedge clk);
    fl_valid = 1'b0;
    st_valid = 1'b1; st_addr = 32'hE000_0010; st_data = 64'h0000_0000_BEEF_0004;
    #1 chk("R9", "draining queue store stalled", st_stall, 1);
    drain_check(0, exp_dest(32'hE000_0000, 0, '0), 0, "R9");
    chk("R9", "stall released after burst", st_stall, 0);
    @(negedge clk);
    st_valid = 1'b0;
    model[0][4] = 32'hBEEF_0004;
    flush(32'hE000_0000, 0, '0, 1);
    drain_check(0, exp_dest(32'hE000_0000, 0, '0), 0, "R10");
    flush(32'hE000_0020, 0, '0, 1);
    drain_check(1, exp_dest(32'hE000_0020, 0, '0), 0, "R8");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    st_valid = 1'b0; st_addr = '0; st_quad = 1'b0; st_data = '0;
    fl_valid = 1'b0; fl_addr = '0; xlat_en = 1'b0; xlat_page = '0;
    base_we = 1'b0; base_sel = 1'b0; base_data = '0; bw_ready = 1'b0;
    base_m[0] = '0; base_m[1] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_longword();
    t_quad();
    t_xlat();
    t_ignore();
    t_pingpong();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule